// File: doc/BRIEF.md
# Three-Slot Wait-Free Data Pool

This block passes one data item at a time from a writer to a reader. The two sides work independently and neither waits on the other's data access. Each side has its own four-phase request/acknowledge handshake and may stretch it as long as it likes. Three storage slots are managed by three slot registers. Each register is one-hot on three bits: bit 0 is slot 1, bit 1 is slot 2 and bit 2 is slot 3.

- `nxt` is the slot the next write will fill.
- `lst` is the slot most recently completed.
- `cur` is the slot the reader is using.

A write stores the input into `nxt`, then copies `nxt` into `lst`. It then picks a new `nxt` that is neither the new `lst` nor `cur`. When `lst` equals `cur`, the pick is the slot after it in rotation (1→2, 2→3, 3→1). A read first copies `lst` into `cur` and then fetches slot `cur`.

The copy steps go through a small mutex, so only one side updates the registers in a cycle. On a simultaneous request the mutex alternates between the sides. The first such tie after reset goes to the writer. The slot data accesses run outside the mutex.

The parameter `SIGNAL_MODE` selects one of two reader behaviours:
- **0 (pool):** the reader may fetch the same item again.
- **1 (signal):** the reader holds off until a write has completed since its last fetch.

Top module: `tsp_pool`

## Requirements
- R1: After a synchronous reset, `wr_ack`, `rd_ack` and `ctl_err` are low. A first pool-mode read returns zero, because reset sets `lst`=`cur`=slot 1 (clearing that slot) and sets `nxt`=slot 2.
- R2: In pool mode, a read started after a write's acknowledge returns the data of the most recently acknowledged write.
- R3: In pool mode, a read with no write since the previous read returns the same data again.
- R4: In signal mode, a read request gets no acknowledge while no write has completed since the previous fetch (or since reset). Once a write completes, the read returns that write's data.
- R5: While `rd_ack` is high, `rd_data` holds its value even when several writes complete meanwhile, and the write never targets the slot being read. The read that follows returns the newest write.
- R6: A write is acknowledged no more than 3 clock cycles after `wr_req` is first seen high, whatever the reader is doing.
- R7: At most one side holds the mutex in a cycle. On a tie the grant alternates, and the first tie after reset goes to the writer. So a read and a write requested on the same edge return the new data on the first tie and the old data on the second.
- R8: Both handshakes are four-phase: an acknowledge stays high while its request stays high, and falls on the first edge after the request drops.
- R9: `ctl_err` goes high when any slot register is not one-hot. Under legal traffic it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_req | input | 1 | Writer request, held until `wr_ack` |
| wr_data | input | DW | Data to store, sampled on the first edge that sees `wr_req` |
| wr_ack | output | 1 | Write complete |
| rd_req | input | 1 | Reader request, held until `rd_ack` |
| rd_data | output | DW | Fetched data, valid while `rd_ack` is high |
| rd_ack | output | 1 | Read data valid |
| ctl_err | output | 1 | A slot register left one-hot encoding |

## Verification
The bench issues a read and a write on the same edge twice. A design that does not alternate the mutex, or that favours the reader first, returns the old value on the first tie and fails R7.

It holds a read open across four completed writes. A design that lets `nxt` land on `cur` corrupts `rd_data` mid-access.

In signal mode it leaves the reader spinning with no fresh data. This exposes a reader that re-fetches stale data, and a writer that starves behind a busy mutex. The lost tie makes the writer's acknowledge take longer than 3 cycles.

// File: rtl/tsp_pkg.sv
package tsp_pkg;
  localparam int NSLOT = 3;
  localparam int IDXW  = 2;
  typedef logic [NSLOT-1:0] slot_t;
  localparam slot_t SLOT_A = 3'b001;
  localparam slot_t SLOT_B = 3'b010;

  // slot free of both the last-written and the being-read slot
  function automatic slot_t pick_free(slot_t last_s, slot_t read_s);
    if (last_s == read_s) return {last_s[NSLOT-2:0], last_s[NSLOT-1]};
    else                  return ~(last_s | read_s);
  endfunction

  function automatic logic [IDXW-1:0] slot_index(slot_t s);
    case (s)
      3'b010:  return 2'd1;
      3'b100:  return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic is_onehot(slot_t s);
    return (s != '0) && ((s & (s - slot_t'(1))) == '0);
  endfunction
endpackage

// File: rtl/tsp_mutex.sv
module tsp_mutex (
  input  logic clk,
  input  logic rst,
  input  logic req_w,
  input  logic req_r,
  output logic gnt_w,
  output logic gnt_r
);
  logic prefer_r;
  logic tie;

  assign tie   = req_w & req_r;
  assign gnt_w = req_w & (~req_r | ~prefer_r);
  assign gnt_r = req_r & (~req_w | prefer_r);

  always_ff @(posedge clk) begin
    if (rst)      prefer_r <= 1'b0;
    else if (tie) prefer_r <= ~prefer_r;
  end

  assert_mutex_excl_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({gnt_w, gnt_r}));
  assert_tie_alt_w_R7: assert property (@(posedge clk) disable iff (rst)
    (tie && gnt_w) |=> (!(req_w && req_r) || gnt_r));
  assert_tie_alt_r_R7: assert property (@(posedge clk) disable iff (rst)
    (tie && gnt_r) |=> (!(req_w && req_r) || gnt_w));
endmodule

// File: rtl/tsp_wr_ctrl.sv
module tsp_wr_ctrl
  import tsp_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  wr_req,
  output logic  wr_ack,
  output logic  mreq,
  input  logic  mgnt,
  input  slot_t cur_s,
  output slot_t nxt_s,
  output slot_t lst_s,
  output logic  mem_we
);
  typedef enum logic [1:0] {W_IDLE, W_LOCK, W_DONE} wst_t;
  wst_t st;
  logic [1:0] wait_cnt;

  assign mreq   = (st == W_LOCK);
  assign mem_we = (st == W_IDLE) && wr_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= W_IDLE;
      wr_ack <= 1'b0;
      nxt_s  <= SLOT_B;
      lst_s  <= SLOT_A;
    end else begin
      case (st)
        W_IDLE: if (wr_req) st <= W_LOCK;
        W_LOCK: if (mgnt) begin
          lst_s  <= nxt_s;
          nxt_s  <= pick_free(nxt_s, cur_s);
          wr_ack <= 1'b1;
          st     <= W_DONE;
        end
        W_DONE: if (!wr_req) begin
          wr_ack <= 1'b0;
          st     <= W_IDLE;
        end
        default: st <= W_IDLE;
      endcase
    end
  end

  // cycles spent waiting for the mutex
  always_ff @(posedge clk) begin
    if (rst)                                    wait_cnt <= '0;
    else if (st == W_LOCK && !mgnt && wait_cnt != 2'd3) wait_cnt <= wait_cnt + 2'd1;
    else if (st != W_LOCK || mgnt)              wait_cnt <= '0;
  end

  assert_wr_waitfree_R6: assert property (@(posedge clk) disable iff (rst)
    wait_cnt < 2'd2);
  assert_slot_free_R5: assert property (@(posedge clk) disable iff (rst)
    ((nxt_s & lst_s) == '0) && ((nxt_s & cur_s) == '0));
  assert_wack_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_ack && wr_req) |=> wr_ack);
endmodule

// File: rtl/tsp_rd_ctrl.sv
module tsp_rd_ctrl
  import tsp_pkg::*;
#(
  parameter bit SIGNAL_MODE = 1'b0
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  rd_req,
  output logic  rd_ack,
  output logic  mreq,
  input  logic  mgnt,
  input  slot_t lst_s,
  output slot_t cur_s,
  output logic  mem_re
);
  typedef enum logic [1:0] {R_IDLE, R_LOCK, R_FETCH, R_DONE} rst_t;
  rst_t st;
  logic stale;

  generate
    if (SIGNAL_MODE) begin : g_signal
      assign stale = (cur_s == lst_s);
    end else begin : g_pool
      assign stale = 1'b0;
    end
  endgenerate

  assign mreq   = (st == R_LOCK);
  assign mem_re = (st == R_FETCH);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= R_IDLE;
      rd_ack <= 1'b0;
      cur_s  <= SLOT_A;
    end else begin
      case (st)
        R_IDLE:  if (rd_req) st <= R_LOCK;
        R_LOCK:  if (mgnt && !stale) begin
          cur_s <= lst_s;
          st    <= R_FETCH;
        end
        R_FETCH: begin
          rd_ack <= 1'b1;
          st     <= R_DONE;
        end
        R_DONE:  if (!rd_req) begin
          rd_ack <= 1'b0;
          st     <= R_IDLE;
        end
        default: st <= R_IDLE;
      endcase
    end
  end

  assert_stale_wait_R4: assert property (@(posedge clk) disable iff (rst)
    (st == R_LOCK && mgnt && stale) |=> (st == R_LOCK && $stable(cur_s)));
  assert_rack_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_ack && rd_req) |=> rd_ack);
endmodule

// File: rtl/tsp_slot_ram.sv
module tsp_slot_ram #(
  parameter int DW    = 16,
  parameter int DEPTH = 3,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

  assert_no_clash_R5: assert property (@(posedge clk) disable iff (rst)
    re |-> !(we && waddr == raddr));
endmodule

// File: rtl/tsp_pool.sv
module tsp_pool
  import tsp_pkg::*;
#(
  parameter int DW          = 16,
  parameter bit SIGNAL_MODE = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_req,
  input  logic [DW-1:0] wr_data,
  output logic          wr_ack,
  input  logic          rd_req,
  output logic [DW-1:0] rd_data,
  output logic          rd_ack,
  output logic          ctl_err
);
  slot_t nxt_s, lst_s, cur_s;
  logic  w_mreq, w_mgnt, r_mreq, r_mgnt;
  logic  w_we, r_re;
  logic            ram_we;
  logic [IDXW-1:0] ram_waddr;
  logic [DW-1:0]   ram_wdata;

  tsp_mutex u_mutex (
    .clk(clk), .rst(rst),
    .req_w(w_mreq), .req_r(r_mreq),
    .gnt_w(w_mgnt), .gnt_r(r_mgnt)
  );

  tsp_wr_ctrl u_wr (
    .clk(clk), .rst(rst),
    .wr_req(wr_req), .wr_ack(wr_ack),
    .mreq(w_mreq), .mgnt(w_mgnt),
    .cur_s(cur_s), .nxt_s(nxt_s), .lst_s(lst_s),
    .mem_we(w_we)
  );

  tsp_rd_ctrl #(.SIGNAL_MODE(SIGNAL_MODE)) u_rd (
    .clk(clk), .rst(rst),
    .rd_req(rd_req), .rd_ack(rd_ack),
    .mreq(r_mreq), .mgnt(r_mgnt),
    .lst_s(lst_s), .cur_s(cur_s),
    .mem_re(r_re)
  );

  // reset clears the slot the reader starts on, through the normal write port
  assign ram_we    = rst | w_we;
  assign ram_waddr = rst ? '0 : slot_index(nxt_s);
  assign ram_wdata = rst ? '0 : wr_data;

  tsp_slot_ram #(.DW(DW), .DEPTH(NSLOT)) u_ram (
    .clk(clk), .rst(rst),
    .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .re(r_re), .raddr(slot_index(cur_s)), .rdata(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) ctl_err <= 1'b0;
    else     ctl_err <= !is_onehot(nxt_s) || !is_onehot(lst_s) || !is_onehot(cur_s);
  end

  assert_ctl_ok_R9: assert property (@(posedge clk) disable iff (rst)
    !ctl_err);
  assert_rdata_hold_R5: assert property (@(posedge clk) disable iff (rst)
    rd_ack |=> $stable(rd_data));
endmodule

// File: tb/tb_tsp_pool.sv
module tb_tsp_pool;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst;
  logic [1:0] wr_req, rd_req, wr_ack, rd_ack, ctl_err;
  logic [DW-1:0] wr_data [2];
  logic [DW-1:0] rd_data [2];

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [DW-1:0] exp_q0[$], exp_q1[$];
  string tag_q0[$], tag_q1[$];
  logic [1:0] ack_prev;

  always #10 clk = ~clk;  // 50 MHz

  tsp_pool #(.DW(DW), .SIGNAL_MODE(1'b0)) dut (
    .clk(clk), .rst(rst),
    .wr_req(wr_req[0]), .wr_data(wr_data[0]), .wr_ack(wr_ack[0]),
    .rd_req(rd_req[0]), .rd_data(rd_data[0]), .rd_ack(rd_ack[0]),
    .ctl_err(ctl_err[0])
  );

  tsp_pool #(.DW(DW), .SIGNAL_MODE(1'b1)) dut_sig (
    .clk(clk), .rst(rst),
    .wr_req(wr_req[1]), .wr_data(wr_data[1]), .wr_ack(wr_ack[1]),
    .rd_req(rd_req[1]), .rd_data(rd_data[1]), .rd_ack(rd_ack[1]),
    .ctl_err(ctl_err[1])
  );

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on each rising read acknowledge
  always @(negedge clk) begin
    if (rst) ack_prev <= 2'b00;
    else begin
      for (int k = 0; k < 2; k++) begin
        if (rd_ack[k] && !ack_prev[k]) begin
          logic [DW-1:0] e;
          string t;
          if (k == 0) begin
            if (exp_q0.size() == 0) begin e = 'x; t = "R2"; end
            else begin e = exp_q0.pop_front(); t = tag_q0.pop_front(); end
          end else begin
            if (exp_q1.size() == 0) begin e = 'x; t = "R4"; end
            else begin e = exp_q1.pop_front(); t = tag_q1.pop_front(); end
          end
          chk(rd_data[k] === e, t, "rd_data", rd_data[k], e);
        end
      end
      ack_prev <= rd_ack;
    end
  end

  task automatic do_write(int k, logic [DW-1:0] v);
    int cyc = 0;
    @(negedge clk);
    wr_data[k] = v;
    wr_req[k]  = 1'b1;
    do begin @(negedge clk); cyc++; end while (!wr_ack[k] && cyc < 50);
    chk(cyc <= 3, "R6", "write ack latency", cyc, 3);
    wr_req[k] = 1'b0;
    @(negedge clk);
    chk(wr_ack[k] == 1'b0, "R8", "wr_ack release", wr_ack[k], 0);
  endtask

  task automatic push_exp(int k, logic [DW-1:0] v, string t);
    if (k == 0) begin exp_q0.push_back(v); tag_q0.push_back(t); end
    else        begin exp_q1.push_back(v); tag_q1.push_back(t); end
  endtask

  task automatic rd_raise(int k);
    @(negedge clk);
    rd_req[k] = 1'b1;
  endtask

  task automatic rd_wait(int k, string t);
    int cyc = 0;
    while (!rd_ack[k] && cyc < 200) begin @(negedge clk); cyc++; end
    chk(rd_ack[k] == 1'b1, t, "rd_ack arrives", rd_ack[k], 1);
  endtask

  task automatic rd_drop(int k);
    rd_req[k] = 1'b0;
    @(negedge clk);
    chk(rd_ack[k] == 1'b0, "R8", "rd_ack release", rd_ack[k], 0);
  endtask

  task automatic do_read(int k, logic [DW-1:0] v, string t);
    push_exp(k, v, t);
    rd_raise(k);
    rd_wait(k, t);
    rd_drop(k);
  endtask

  initial begin
    rst = 1'b1;
    wr_req = '0; rd_req = '0;
    wr_data[0] = '0; wr_data[1] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state and cleared initial slot
    chk(wr_ack == 2'b00, "R1", "wr_ack after reset", wr_ack, 0);
    chk(rd_ack == 2'b00, "R1", "rd_ack after reset", rd_ack, 0);
    chk(ctl_err == 2'b00, "R1", "ctl_err after reset", ctl_err, 0);
    do_read(0, 16'h0000, "R1");

    // R2 newest acknowledged write
    do_write(0, 16'hA001);
    do_read(0, 16'hA001, "R2");
    do_write(0, 16'hA002);
    do_write(0, 16'hA003);
    do_read(0, 16'hA003, "R2");

    // R3 re-read in pool mode
    do_read(0, 16'hA003, "R3");
    do_read(0, 16'hA003, "R3");

    // R5 coherence while a read is held open
    do_write(0, 16'hB000);
    push_exp(0, 16'hB000, "R5");
    rd_raise(0);
    rd_wait(0, "R5");
    for (int i = 1; i <= 4; i++) begin
      do_write(0, 16'hB000 + 16'(i));
      chk(rd_data[0] == 16'hB000, "R5", "rd_data held", rd_data[0], 16'hB000);
    end
    rd_drop(0);
    do_read(0, 16'hB004, "R5");

    // R7 simultaneous requests: first tie writer, second tie reader
    push_exp(0, 16'hC001, "R7");
    fork
      do_write(0, 16'hC001);
      begin rd_raise(0); rd_wait(0, "R7"); rd_drop(0); end
    join
    repeat (2) @(negedge clk);
    push_exp(0, 16'hC001, "R7");
    fork
      do_write(0, 16'hC002);
      begin rd_raise(0); rd_wait(0, "R7"); rd_drop(0); end
    join
    do_read(0, 16'hC002, "R7");

    // R4 signal mode: no fresh data holds the reader off
    push_exp(1, 16'hD001, "R4");
    rd_raise(1);
    repeat (10) @(negedge clk);
    chk(rd_ack[1] == 1'b0, "R4", "no ack before first write", rd_ack[1], 0);
    do_write(1, 16'hD001);
    rd_wait(1, "R4");
    rd_drop(1);

    push_exp(1, 16'hD002, "R4");
    rd_raise(1);
    repeat (8) @(negedge clk);
    chk(rd_ack[1] == 1'b0, "R4", "no ack on stale data", rd_ack[1], 0);
    do_write(1, 16'hD002);
    rd_wait(1, "R4");
    rd_drop(1);

    do_write(1, 16'hD003);
    do_write(1, 16'hD004);
    do_read(1, 16'hD004, "R4");

    repeat (4) @(negedge clk);
    chk(ctl_err == 2'b00, "R9", "ctl_err after traffic", ctl_err, 0);
    chk(exp_q0.size() == 0 && exp_q1.size() == 0, "R2", "scoreboard drained",
        exp_q0.size() + exp_q1.size(), 0);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL R6 watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule